// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O SRAM with Single-Error Correction

A synchronous static memory model in one clock domain. Address and control are sampled once per clock edge, at a single data rate. Each cycle carries at most one command: a read or a write. Every command moves a burst of four beats, and one array word holds the whole burst. Write data and read data use separate ports.

The four beats travel as one parallel vector with beat 0 in the least-significant lane. A write is first held for one cycle in a staging register, which plays the part of the input demultiplexer, and is then written to the array in a single access. A read fetches one array word and passes it through a single-error-correcting decoder. The corrected burst appears at the output a fixed five cycles after the command.

Each stored word carries Hamming check bits. A test port can flip any one bit of the codeword as it is written. This lets the correction path be exercised through the normal ports.

Top module: `sq_burst_sram`

## Requirements
- R1: A cycle with `wr_en` high is a write. A cycle with only `rd_en` high is a read. When both strobes are high, the write is performed and the read is dropped: no `rd_valid` results from it.
- R2: For a read sampled at clock edge k, `rd_valid` is high, with the read result, for exactly the one cycle that follows edge k+4. Reads on consecutive cycles give `rd_valid` on consecutive cycles.
- R3: A burst is four beats of DATA_W bits, with beat b at bits [b*DATA_W +: DATA_W] of `wr_data` and `rd_data`. A read returns all four beats of the last write to that burst address, in the same lanes.
- R4: The burst address `addr` has ADDR_W bits and selects one of 2**ADDR_W bursts, which is 4*2**ADDR_W beats. Any sequence of reads and writes to any addresses gives correct data.
- R5: A write is held in the staging register for the cycle after it is sampled. A read sampled in that cycle, to the same address, returns the newly written data.
- R6: Reset clears every array word. Any read after reset, before a write to that address, returns all zero with `rd_corrected` low.
- R7: The codeword is 4*DATA_W data bits plus the smallest number of check bits p with 2**p >= 4*DATA_W+p+1; that is 38 bits for the defaults. A write with `inj_en` high and `inj_pos` below the codeword width stores the word with codeword bit `inj_pos` inverted. A later read of that address returns the original data with `rd_corrected` high.
- R8: Injection has no effect in any of these cases: `inj_en` is low, `inj_pos` is at or above the codeword width, or the command is a read. In each case the read returns the written data with `rd_corrected` low.
- R9: While `rd_valid` is low, `rd_data` is all zero and `rd_corrected` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe; takes priority over the read strobe |
| addr | input | ADDR_W | Burst address |
| wr_data | input | 4*DATA_W | Write burst, beat 0 in the low lane |
| inj_en | input | 1 | Invert one stored codeword bit for this write |
| inj_pos | input | POS_W | Index of the codeword bit to invert |
| rd_data | output | 4*DATA_W | Corrected read burst, beat 0 in the low lane |
| rd_valid | output | 1 | Read result present this cycle |
| rd_corrected | output | 1 | The decoder repaired one bit of this result |

## Verification
Several internal faults show up at the read port. An error in the staging register or the forwarding compare shows up on the very next read of the address just written, five cycles after that read. A wrong lane or a wrong stored word shows up as a beat mismatch when that address is next read. A delay fault moves `rd_valid` by a cycle and is visible immediately, both in the cycle that expected data and in the neighbouring idle cycle. An encoder or decoder fault, with or without an injected flip, appears as wrong data or a wrong `rd_corrected` on the first read of the affected word.

// File: rtl/sq_pkg.sv
package sq_pkg;

    localparam int MASK_MAX = 256;

    // Smallest p with 2**p >= k + p + 1 (single-error-correcting Hamming).
    function automatic int chk_bits(input int k);
        for (int p = 1; p < 16; p++) begin
            if ((1 << p) >= k + p + 1) return p;
        end
        return 16;
    endfunction

    // Codeword positions (1-based) whose index has bit j set; bit 0 = position 1.
    function automatic logic [MASK_MAX-1:0] cover_mask(input int j, input int n);
        logic [MASK_MAX-1:0] m;
        m = '0;
        for (int pos = n; pos >= 1; pos--) begin
            m = {m[MASK_MAX-2:0], (((pos >> j) & 1) != 0)};
        end
        return m;
    endfunction

endpackage

// File: rtl/sq_ecc_enc.sv
module sq_ecc_enc #(
    parameter int K = 32
) (
    input  logic [K-1:0]                          data,
    output logic [K+sq_pkg::chk_bits(K)-1:0]      cw
);
    localparam int P = sq_pkg::chk_bits(K);
    localparam int N = K + P;

    logic [N-1:0] raw;
    logic [P-1:0] par;

    // Data bits fill the non-power-of-two positions in order.
    for (genvar p = 1; p <= N; p++) begin : g_pos
        if ((p & (p - 1)) != 0) begin : g_dat
            assign raw[p-1] = data[p - 1 - $clog2(p + 1)];
            assign cw[p-1]  = raw[p-1];
        end else begin : g_chk
            assign raw[p-1] = 1'b0;
            assign cw[p-1]  = par[$clog2(p)];
        end
    end

    for (genvar j = 0; j < P; j++) begin : g_par
        localparam logic [sq_pkg::MASK_MAX-1:0] MSK = sq_pkg::cover_mask(j, N);
        assign par[j] = ^(raw & MSK[N-1:0]);
    end
endmodule

// File: rtl/sq_ecc_dec.sv
module sq_ecc_dec #(
    parameter int K = 32
) (
    input  logic [K+sq_pkg::chk_bits(K)-1:0] cw,
    output logic [K-1:0]                     data,
    output logic                             corr
);
    localparam int P = sq_pkg::chk_bits(K);
    localparam int N = K + P;

    logic [P-1:0] syn;
    logic [N-1:0] flip;
    logic [N-1:0] fixed;

    for (genvar j = 0; j < P; j++) begin : g_syn
        localparam logic [sq_pkg::MASK_MAX-1:0] MSK = sq_pkg::cover_mask(j, N);
        assign syn[j] = ^(cw & MSK[N-1:0]);
    end

    always_comb begin
        flip = '0;
        if (syn != '0) flip = N'(1) << (syn - P'(1));
        fixed = cw ^ flip;
        corr  = (syn != '0);
    end

    for (genvar p = 1; p <= N; p++) begin : g_ext
        if ((p & (p - 1)) != 0) begin : g_dat
            assign data[p - 1 - $clog2(p + 1)] = fixed[p-1];
        end
    end
endmodule

// File: rtl/sq_array.sv
module sq_array #(
    parameter int ADDR_W = 4,
    parameter int CW_W   = 38,
    parameter int POS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              rd_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW_W-1:0]   wr_cw,
    input  logic              inj_en,
    input  logic [POS_W-1:0]  inj_pos,
    output logic              s1_vld,
    output logic [CW_W-1:0]   s1_cw
);
    localparam int WORDS = 1 << ADDR_W;

    typedef struct packed {
        logic              pend_vld;
        logic [ADDR_W-1:0] pend_addr;
        logic [CW_W-1:0]   pend_cw;
        logic              s1_vld;
        logic [CW_W-1:0]   s1_cw;
    } st_t;

    st_t st_d, st_q;
    logic [CW_W-1:0] mem [WORDS];
    logic [CW_W-1:0] inj_mask;
    logic            fwd_hit;

    always_comb begin
        inj_mask = '0;
        if (inj_en && (32'(inj_pos) < CW_W)) inj_mask = CW_W'(1) << inj_pos;
        fwd_hit = st_q.pend_vld && (st_q.pend_addr == addr);

        st_d = st_q;
        // staging register: one write waits here for one cycle
        st_d.pend_vld = wr_cmd;
        if (wr_cmd) begin
            st_d.pend_addr = addr;
            st_d.pend_cw   = wr_cw ^ inj_mask;
        end
        // first read stage: array fetch, newest staged write wins
        st_d.s1_vld = rd_cmd;
        st_d.s1_cw  = '0;
        if (rd_cmd) st_d.s1_cw = fwd_hit ? st_q.pend_cw : mem[addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (st_q.pend_vld) begin
            mem[st_q.pend_addr] <= st_q.pend_cw;
        end
    end

    assign s1_vld = st_q.s1_vld;
    assign s1_cw  = st_q.s1_cw;

    // R5: a sampled write occupies the staging register in the next cycle
    assert_write_staged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> (st_q.pend_vld && st_q.pend_addr == $past(addr)));
endmodule

// File: rtl/sq_rd_pipe.sv
module sq_rd_pipe #(
    parameter int K     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_in,
    input  logic [K-1:0] data_in,
    input  logic         corr_in,
    output logic         vld_out,
    output logic [K-1:0] data_out,
    output logic         corr_out
);
    typedef struct packed {
        logic         vld;
        logic         corr;
        logic [K-1:0] data;
    } stg_t;

    stg_t [DEPTH-1:0] pipe_d, pipe_q;
    stg_t             head;

    always_comb begin
        head.vld  = vld_in;
        head.corr = corr_in & vld_in;
        head.data = data_in & {K{vld_in}};
        pipe_d    = {pipe_q[DEPTH-2:0], head};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign vld_out  = pipe_q[DEPTH-1].vld;
    assign corr_out = pipe_q[DEPTH-1].corr;
    assign data_out = pipe_q[DEPTH-1].data;
endmodule

// File: rtl/sq_burst_sram.sv
module sq_burst_sram #(
    parameter  int DATA_W  = 8,
    parameter  int ADDR_W  = 4,
    parameter  int RD_LAT  = 5,
    localparam int BURST_W = 4 * DATA_W,
    localparam int CHK_W   = sq_pkg::chk_bits(BURST_W),
    localparam int CW_W    = BURST_W + CHK_W,
    localparam int POS_W   = $clog2(CW_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BURST_W-1:0] wr_data,
    input  logic               inj_en,
    input  logic [POS_W-1:0]   inj_pos,
    output logic [BURST_W-1:0] rd_data,
    output logic               rd_valid,
    output logic               rd_corrected
);
    localparam int PIPE_D = RD_LAT - 1;
    localparam int CYC_W  = $clog2(RD_LAT + 1);

    logic               wr_cmd, rd_cmd;
    logic [CW_W-1:0]    wr_cw, s1_cw;
    logic               s1_vld;
    logic [BURST_W-1:0] dec_data;
    logic               dec_corr;

    assign wr_cmd = wr_en;
    assign rd_cmd = rd_en & ~wr_en;

    sq_ecc_enc #(.K(BURST_W)) u_enc (
        .data (wr_data),
        .cw   (wr_cw)
    );

    sq_array #(.ADDR_W(ADDR_W), .CW_W(CW_W), .POS_W(POS_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .rd_cmd  (rd_cmd),
        .addr    (addr),
        .wr_cw   (wr_cw),
        .inj_en  (inj_en),
        .inj_pos (inj_pos),
        .s1_vld  (s1_vld),
        .s1_cw   (s1_cw)
    );

    sq_ecc_dec #(.K(BURST_W)) u_dec (
        .cw   (s1_cw),
        .data (dec_data),
        .corr (dec_corr)
    );

    sq_rd_pipe #(.K(BURST_W), .DEPTH(PIPE_D)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_in   (s1_vld),
        .data_in  (dec_data),
        .corr_in  (dec_corr),
        .vld_out  (rd_valid),
        .data_out (rd_data),
        .corr_out (rd_corrected)
    );

    // cycles since reset, saturating; gates the latency check below
    logic [CYC_W-1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                       cyc_q <= '0;
        else if (cyc_q != CYC_W'(RD_LAT)) cyc_q <= cyc_q + CYC_W'(1);
    end

    initial assert (RD_LAT >= 3) else $error("RD_LAT below 3");

    assert_valid_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_cmd, RD_LAT));

    assert_read_gives_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_W'(RD_LAT) && $past(rd_cmd, RD_LAT)) |-> rd_valid);

    assert_corr_only_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_corrected |-> rd_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && !rd_corrected));
endmodule

// File: tb/sq_burst_sram_bench.sv
module sq_burst_sram_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int BW = 4 * DW;

    function automatic int calc_chk(input int k);
        int p;
        p = 1;
        while ((1 << p) < k + p + 1) p++;
        return p;
    endfunction

    localparam int CW = BW + calc_chk(BW);
    localparam int PW = $clog2(CW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0, inj_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [PW-1:0] inj_pos = '0;
    logic [BW-1:0] rd_data;
    logic          rd_valid, rd_corrected;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sq_burst_sram #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(5)) u_sq_burst_sram (
        .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .wr_en (wr_en),
        .addr (addr), .wr_data (wr_data), .inj_en (inj_en), .inj_pos (inj_pos),
        .rd_data (rd_data), .rd_valid (rd_valid), .rd_corrected (rd_corrected)
    );

    int total = 0, bad = 0, n = 0;
    bit finished = 0;

    logic [BW-1:0] m_data [1 << AW];
    logic          m_corr [1 << AW];
    logic          ev [8];
    logic [BW-1:0] ed [8];
    logic          ec [8];
    string         et [8];

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (step %0d)", tag, what, act, exp, n);
        end
    endtask

    task automatic step(input logic r, input logic w, input logic [AW-1:0] a,
                        input logic [BW-1:0] d, input logic ie,
                        input logic [PW-1:0] ip, input string tag);
        int s, f;
        @(negedge clk);
        s = n % 8;
        if (ev[s]) begin
            chk(et[s], "rd_valid", 64'(rd_valid), 64'd1);
            chk(et[s], "rd_data", 64'(rd_data), 64'(ed[s]));
            chk(et[s], "rd_corrected", 64'(rd_corrected), 64'(ec[s]));
        end else begin
            chk("R9", "idle rd_valid", 64'(rd_valid), 64'd0);
            chk("R9", "idle rd_data/corr", {31'd0, rd_corrected, rd_data}, 64'd0);
        end
        ev[s] = 1'b0;
        rd_en = r; wr_en = w; addr = a; wr_data = d; inj_en = ie; inj_pos = ip;
        if (w) begin
            m_data[a] = d;
            m_corr[a] = ie && (int'(ip) < CW);
        end else if (r) begin
            f = (n + 5) % 8;
            ev[f] = 1'b1; ed[f] = m_data[a]; ec[f] = m_corr[a]; et[f] = tag;
        end
        n++;
    endtask

    task automatic idle(input int cnt);
        for (int i = 0; i < cnt; i++) step(0, 0, '0, '0, 0, '0, "R9");
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin m_data[i] = '0; m_corr[i] = 1'b0; end
        for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; ed[i] = '0; ec[i] = 1'b0; et[i] = ""; end
        void'($urandom(32'h5eed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R6: nothing valid after reset, cleared array reads zero
        idle(3);
        step(1, 0, 4'd0, '0, 0, '0, "R6");
        step(1, 0, 4'd15, '0, 0, '0, "R6");
        idle(6);
        // R5: read right after write to the same address sees the new data
        step(0, 1, 4'd3, 32'hA1B2C3D4, 0, '0, "R5");
        step(1, 0, 4'd3, '0, 0, '0, "R5");
        step(0, 1, 4'd3, 32'h0F1E2D3C, 0, '0, "R5");
        step(1, 0, 4'd3, '0, 0, '0, "R5");
        // R3: beat lanes, beat 0 = 0x11 in the low byte
        step(0, 1, 4'd5, 32'h44332211, 0, '0, "R3");
        idle(2);
        step(1, 0, 4'd5, '0, 0, '0, "R3");
        // R1: both strobes -> write only, no read result
        step(1, 1, 4'd7, 32'hCAFE0077, 0, '0, "R1");
        idle(6);
        step(1, 0, 4'd7, '0, 0, '0, "R1");
        // R2: back-to-back reads give back-to-back results
        step(1, 0, 4'd3, '0, 0, '0, "R2");
        step(1, 0, 4'd5, '0, 0, '0, "R2");
        step(1, 0, 4'd7, '0, 0, '0, "R2");
        idle(6);
        // R7: single flips in check and data positions are repaired
        step(0, 1, 4'd9,  32'h12345678, 1, PW'(0), "R7");
        step(0, 1, 4'd10, 32'h9ABCDEF0, 1, PW'(CW - 1), "R7");
        step(0, 1, 4'd11, 32'h55AA55AA, 1, PW'(10), "R7");
        step(1, 0, 4'd9,  '0, 0, '0, "R7");
        step(1, 0, 4'd10, '0, 0, '0, "R7");
        step(1, 0, 4'd11, '0, 0, '0, "R7");
        // R8: injection ignored when out of range, disabled, or on a read
        step(0, 1, 4'd12, 32'h0BADF00D, 1, PW'(CW), "R8");
        step(0, 1, 4'd13, 32'hDEADBEEF, 1, PW'((1 << PW) - 1), "R8");
        step(0, 1, 4'd14, 32'h13572468, 0, PW'(5), "R8");
        step(1, 0, 4'd12, '0, 0, '0, "R8");
        step(1, 0, 4'd13, '0, 0, '0, "R8");
        step(1, 0, 4'd14, '0, 0, '0, "R8");
        step(1, 0, 4'd3,  '0, 1, PW'(4), "R8");
        idle(6);
        // R4: random traffic over the full address range
        for (int i = 0; i < 1500; i++) begin
            logic [1:0] op;
            logic ie;
            op = 2'($urandom_range(0, 3));
            ie = ($urandom_range(0, 3) == 0);
            step(op[0], op[1], AW'($urandom), BW'($urandom), ie,
                 PW'($urandom_range(0, (1 << PW) - 1)), "R4");
        end
        idle(8);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", n);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule